// File: doc/BRIEF.md
# Dual-Core Mailbox with Interrupt Handshake

This block joins two processor cores that share one clock. Each core has its own register port, made of separate write and read strobes, a word address and a 32-bit data path. Through that port a core sends 32-bit words to the other core. Four channels run in each direction. Every channel is a single-word slot. Writing a slot marks it occupied for the receiver. Reading the slot on the far side frees it for the sender.

Each side has one status register. It reports which outgoing slots are free and which incoming slots hold a word. It also holds per-channel enables for a "slot free again" interrupt and a "word arrived" interrupt, plus a sticky flag for a write that was refused. Each side drives a level interrupt output. It also drives a wake-up output that a core in a low-power state can use. The wake-up output responds only to enabled arrivals.

Per-side word map with 4 channels:
- Addresses 0 to 3 are the transmit slots (write-only, read as 0).
- Addresses 4 to 7 are the receive slots; a read pops the slot.
- Address 8 is the status register.

Status bit fields:
- [3:0] transmit-free flags, read-only.
- [7:4] receive-occupied flags, read-only.
- [11:8] transmit-interrupt enables.
- [15:12] receive-interrupt enables.
- [16] refused-write flag, cleared by writing 1.

Top module: `mu_mailbox`

## Requirements
- R1: After reset, both status registers read 0x0000000F: all transmit-free flags are 1, all receive-occupied flags are 0, all enables are 0 and the refused-write flag is 0. Both irq and wake outputs are 0.
- R2: A write to transmit slot c (address c) of one side stores the word. From the next cycle, status bit c on the sending side reads 0 and status bit 4+c on the receiving side reads 1.
- R3: A write to a transmit slot whose free flag is 0 is ignored and the stored word is kept. If no read of that slot falls in the same cycle, status bit 16 of the writer is set and stays set. Writing status with bit 16 set clears it.
- R4: A read of receive slot c (address 4+c) returns the stored word. From the next cycle, the receiver's bit 4+c reads 0 and the sender's bit c reads 1. A read of an unoccupied slot changes no flag.
- R5: irq_o of a side is 1 exactly when, for some channel c, either its own transmit-free flag and bit 8+c are both 1, or its receive-occupied flag and bit 12+c are both 1.
- R6: wake_o of a side is 1 exactly when some receive-occupied flag of that side has its enable (bit 12+c) set. Transmit-free events never raise it.
- R7: When the sender writes slot c in the same cycle that the receiver reads slot c, the read returns the old word. The occupied flag stays 1, the new word is read next, and no refused-write flag is set.
- R8: The four channels of both directions are independent. Both sides may send and receive in the same cycle, and every bit of the 32-bit word is carried.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_wr_i | input | 1 | Side A write strobe |
| a_rd_i | input | 1 | Side A read strobe |
| a_addr_i | input | 4 | Side A word address |
| a_wdata_i | input | 32 | Side A write data |
| a_rdata_o | output | 32 | Side A read data, same cycle as the strobe |
| a_irq_o | output | 1 | Side A interrupt |
| a_wake_o | output | 1 | Side A wake-up request |
| b_wr_i | input | 1 | Side B write strobe |
| b_rd_i | input | 1 | Side B read strobe |
| b_addr_i | input | 4 | Side B word address |
| b_wdata_i | input | 32 | Side B write data |
| b_rdata_o | output | 32 | Side B read data, same cycle as the strobe |
| b_irq_o | output | 1 | Side B interrupt |
| b_wake_o | output | 1 | Side B wake-up request |

## Verification
Two events can land on one channel in a single cycle: the sender's write of a slot and the receiver's pop of the same slot. The bench drives both strobes in the same cycle on an occupied slot. It expects the pop to return the earlier word, the slot to stay occupied and no refused-write flag. A second pop must then return the newer word. The bench also contrasts this with a refused write, where no pop coincides with the write, and with both sides sending in one cycle on different channels.

// File: rtl/mu_pkg.sv
package mu_pkg;
  localparam int unsigned NUM_CH = 4;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 4;
endpackage

// File: rtl/mu_chan.sv
// One single-word slot carrying data from a sender to a receiver.
module mu_chan #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ovf_o
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;
  logic              accept;

  // a pop in the same cycle frees the slot for the incoming word
  assign accept = wr_i & (~full_q | rd_i);
  assign ovf_o  = wr_i & full_q & ~rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (accept) data_q <= wdata_i;
      if (accept)    full_q <= 1'b1;
      else if (rd_i) full_q <= 1'b0;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;

  p_fill_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !full_o) |=> full_o);
  p_keep_word_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && full_o && !rd_i) |=> $stable(data_o));
  p_pop_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i) |=> !full_o);
  p_collide_keeps_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && rd_i && full_o) |=> (full_o && data_o == $past(wdata_i)));
endmodule

// File: rtl/mu_side.sv
// Register port of one core: decode, status/enables, read mux, interrupts.
module mu_side #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_i,
  input  logic                          rd_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  input  logic [NUM_CH-1:0]             tx_full_i,
  input  logic [NUM_CH-1:0]             tx_ovf_i,
  input  logic [NUM_CH-1:0]             rx_full_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0] rx_data_i,
  output logic [NUM_CH-1:0]             tx_wr_o,
  output logic [NUM_CH-1:0]             rx_rd_o,
  output logic [DATA_W-1:0]             rdata_o,
  output logic                          irq_o,
  output logic                          wake_o
);
  localparam int unsigned RX_BASE   = NUM_CH;
  localparam int unsigned STAT_ADDR = 2 * NUM_CH;
  localparam int unsigned S_TXE     = 0;
  localparam int unsigned S_RXF     = NUM_CH;
  localparam int unsigned S_TIE     = 2 * NUM_CH;
  localparam int unsigned S_RIE     = 3 * NUM_CH;
  localparam int unsigned S_OVF     = 4 * NUM_CH;

  logic [NUM_CH-1:0] tie_q, rie_q;
  logic              ovf_q;
  logic              stat_wr;
  logic [NUM_CH-1:0] tx_free;

  assign tx_free = ~tx_full_i;
  assign stat_wr = wr_i & (addr_i == ADDR_W'(STAT_ADDR));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    assign tx_wr_o[c] = wr_i & (addr_i == ADDR_W'(c));
    assign rx_rd_o[c] = rd_i & (addr_i == ADDR_W'(RX_BASE + c));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tie_q <= '0;
      rie_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (stat_wr) begin
        tie_q <= wdata_i[S_TIE +: NUM_CH];
        rie_q <= wdata_i[S_RIE +: NUM_CH];
      end
      if (|tx_ovf_i)                      ovf_q <= 1'b1;
      else if (stat_wr && wdata_i[S_OVF]) ovf_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(STAT_ADDR)) begin
      rdata_o[S_TXE +: NUM_CH] = tx_free;
      rdata_o[S_RXF +: NUM_CH] = rx_full_i;
      rdata_o[S_TIE +: NUM_CH] = tie_q;
      rdata_o[S_RIE +: NUM_CH] = rie_q;
      rdata_o[S_OVF]           = ovf_q;
    end else begin
      for (int c = 0; c < int'(NUM_CH); c++) begin
        if (addr_i == ADDR_W'(RX_BASE + c)) rdata_o = rx_data_i[c];
      end
    end
  end

  assign wake_o = |(rx_full_i & rie_q);
  assign irq_o  = wake_o | |(tx_free & tie_q);

  p_ovf_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !(stat_wr && wdata_i[S_OVF])) |=> ovf_q);
  p_wake_implies_irq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> irq_o);
  p_single_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && rd_i) |-> $onehot0({tx_wr_o, rx_rd_o}));
endmodule

// File: rtl/mu_mailbox.sv
module mu_mailbox #(
  parameter int unsigned NUM_CH = mu_pkg::NUM_CH,
  parameter int unsigned DATA_W = mu_pkg::DATA_W,
  parameter int unsigned ADDR_W = mu_pkg::ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_wr_i,
  input  logic              a_rd_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  output logic [DATA_W-1:0] a_rdata_o,
  output logic              a_irq_o,
  output logic              a_wake_o,
  input  logic              b_wr_i,
  input  logic              b_rd_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  output logic [DATA_W-1:0] b_rdata_o,
  output logic              b_irq_o,
  output logic              b_wake_o
);
  logic [NUM_CH-1:0]             a_tx_wr, a_rx_rd, b_tx_wr, b_rx_rd;
  logic [NUM_CH-1:0]             ab_full, ab_ovf, ba_full, ba_ovf;
  logic [NUM_CH-1:0][DATA_W-1:0] ab_data, ba_data;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    mu_chan #(.DATA_W(DATA_W)) u_ab (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .wr_i(a_tx_wr[c]), .rd_i(b_rx_rd[c]), .wdata_i(a_wdata_i),
      .full_o(ab_full[c]), .data_o(ab_data[c]), .ovf_o(ab_ovf[c]));
    mu_chan #(.DATA_W(DATA_W)) u_ba (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .wr_i(b_tx_wr[c]), .rd_i(a_rx_rd[c]), .wdata_i(b_wdata_i),
      .full_o(ba_full[c]), .data_o(ba_data[c]), .ovf_o(ba_ovf[c]));
  end

  mu_side #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_side_a (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(a_wr_i), .rd_i(a_rd_i), .addr_i(a_addr_i), .wdata_i(a_wdata_i),
    .tx_full_i(ab_full), .tx_ovf_i(ab_ovf), .rx_full_i(ba_full), .rx_data_i(ba_data),
    .tx_wr_o(a_tx_wr), .rx_rd_o(a_rx_rd), .rdata_o(a_rdata_o),
    .irq_o(a_irq_o), .wake_o(a_wake_o));

  mu_side #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_side_b (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(b_wr_i), .rd_i(b_rd_i), .addr_i(b_addr_i), .wdata_i(b_wdata_i),
    .tx_full_i(ba_full), .tx_ovf_i(ba_ovf), .rx_full_i(ab_full), .rx_data_i(ab_data),
    .tx_wr_o(b_tx_wr), .rx_rd_o(b_rx_rd), .rdata_o(b_rdata_o),
    .irq_o(b_irq_o), .wake_o(b_wake_o));
endmodule

// File: tb/mu_mailbox_tb_top.sv
`timescale 1ns/1ps
module mu_mailbox_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a_wr = 0, a_rd = 0, b_wr = 0, b_rd = 0;
  logic [3:0]  a_addr = 0, b_addr = 0;
  logic [31:0] a_wd = 0, b_wd = 0;
  logic [31:0] a_rdata, b_rdata;
  logic        a_irq, a_wake, b_irq, b_wake;
  logic [31:0] cap_a, cap_b;
  int          errors = 0, checks = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  mu_mailbox dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .a_wr_i(a_wr), .a_rd_i(a_rd), .a_addr_i(a_addr), .a_wdata_i(a_wd),
    .a_rdata_o(a_rdata), .a_irq_o(a_irq), .a_wake_o(a_wake),
    .b_wr_i(b_wr), .b_rd_i(b_rd), .b_addr_i(b_addr), .b_wdata_i(b_wd),
    .b_rdata_o(b_rdata), .b_irq_o(b_irq), .b_wake_o(b_wake));

  function automatic logic [31:0] stat(input logic [3:0] txe, rxf, tie, rie,
                                       input logic ovf);
    return {15'b0, ovf, rie, tie, rxf, txe};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called just after a negedge; one clock of activity on both ports
  task automatic step(input logic aw, ar, input logic [3:0] aa, input logic [31:0] ad,
                      input logic bw, br, input logic [3:0] ba, input logic [31:0] bd);
    a_wr = aw; a_rd = ar; a_addr = aa; a_wd = ad;
    b_wr = bw; b_rd = br; b_addr = ba; b_wd = bd;
    #1;
    cap_a = a_rdata; cap_b = b_rdata;
    @(negedge clk);
    a_wr = 0; a_rd = 0; b_wr = 0; b_rd = 0; a_addr = 0; b_addr = 0;
  endtask

  task automatic op(input bit side_b, input logic w, r, input logic [3:0] ad,
                    input logic [31:0] d);
    if (side_b) step(0, 0, 0, 0, w, r, ad, d);
    else        step(w, r, ad, d, 0, 0, 0, 0);
  endtask

  task automatic rd_stat(input bit side_b, output logic [31:0] v);
    op(side_b, 0, 1, 4'd8, 0);
    v = side_b ? cap_b : cap_a;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] s, d, d2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 a_irq", {31'b0, a_irq}, 0);
    chk("R1 b_wake", {31'b0, b_wake}, 0);
    rd_stat(0, s); chk("R1 status A", s, 32'h0000000F);
    rd_stat(1, s); chk("R1 status B", s, 32'h0000000F);

    // R2 R4 R8: sweep both directions over all channels
    for (int dir = 0; dir < 2; dir++) begin
      for (int ch = 0; ch < 4; ch++) begin
        d = {8'(ch), 8'(dir), 16'hBEEF} ^ (32'hFFFFFFFF << (ch * 7));
        op(dir[0], 1, 0, 4'(ch), d);
        rd_stat(dir[0], s);
        chk("R2 sender free", s, stat(4'hF & ~(4'b1 << ch), 0, 0, 0, 0));
        rd_stat(!dir[0], s);
        chk("R2 receiver occupied", s, stat(4'hF, 4'b1 << ch, 0, 0, 0));
        op(!dir[0], 0, 1, 4'(4 + ch), 0);
        chk("R8 word carried", dir[0] ? cap_a : cap_b, d);
        rd_stat(!dir[0], s); chk("R4 receiver cleared", s, stat(4'hF, 0, 0, 0, 0));
        rd_stat(dir[0], s);  chk("R4 sender free again", s, stat(4'hF, 0, 0, 0, 0));
      end
    end

    // R8 both sides send in the same cycle, then both pop in the same cycle
    step(1, 0, 4'd0, 32'h1111_2222, 1, 0, 4'd3, 32'h3333_4444);
    rd_stat(0, s); chk("R8 A status", s, stat(4'hE, 4'h8, 0, 0, 0));
    rd_stat(1, s); chk("R8 B status", s, stat(4'h7, 4'h1, 0, 0, 0));
    step(0, 1, 4'd7, 0, 0, 1, 4'd4, 0);
    chk("R8 A pop", cap_a, 32'h3333_4444);
    chk("R8 B pop", cap_b, 32'h1111_2222);

    // R3 refused write
    op(0, 1, 0, 4'd1, 32'hCAFE_0001);
    op(0, 1, 0, 4'd1, 32'hDEAD_0002);
    rd_stat(0, s); chk("R3 overflow set", s, stat(4'hD, 0, 0, 0, 1));
    rd_stat(1, s); chk("R3 other side clean", s, stat(4'hF, 4'h2, 0, 0, 0));
    op(1, 0, 1, 4'd5, 0); chk("R3 old word kept", cap_b, 32'hCAFE_0001);
    rd_stat(0, s); chk("R3 overflow sticky", s, stat(4'hF, 0, 0, 0, 1));
    op(0, 1, 0, 4'd8, 32'h0001_0000);
    rd_stat(0, s); chk("R3 overflow cleared", s, stat(4'hF, 0, 0, 0, 0));

    // R4 pop of an empty slot changes nothing
    op(1, 0, 1, 4'd6, 0);
    rd_stat(1, s); chk("R4 empty pop B", s, stat(4'hF, 0, 0, 0, 0));
    rd_stat(0, s); chk("R4 empty pop A", s, stat(4'hF, 0, 0, 0, 0));

    // R7 write and pop on the same channel in one cycle
    d = 32'h0BAD_F00D; d2 = 32'h600D_CAFE;
    op(0, 1, 0, 4'd2, d);
    step(1, 0, 4'd2, d2, 0, 1, 4'd6, 0);
    chk("R7 pop returns old", cap_b, d);
    rd_stat(1, s); chk("R7 still occupied", s, stat(4'hF, 4'h4, 0, 0, 0));
    rd_stat(0, s); chk("R7 no overflow", s, stat(4'hB, 0, 0, 0, 0));
    op(1, 0, 1, 4'd6, 0); chk("R7 new word next", cap_b, d2);

    // R5 R6 receive interrupt and wake per channel
    for (int ch = 0; ch < 4; ch++) begin
      op(1, 1, 0, 4'd8, 32'((4'b1 << ch)) << 12);
      chk("R5 idle no irq", {30'b0, b_irq, b_wake}, 0);
      op(0, 1, 0, 4'((ch + 1) % 4), 32'h5A5A_0000 + 32'(ch));
      chk("R5 masked channel", {30'b0, b_irq, b_wake}, 0);
      op(1, 0, 1, 4'(4 + (ch + 1) % 4), 0);
      op(0, 1, 0, 4'(ch), 32'hA5A5_0000 + 32'(ch));
      chk("R5 rx irq", {31'b0, b_irq}, 1);
      chk("R6 wake", {31'b0, b_wake}, 1);
      op(1, 0, 1, 4'(4 + ch), 0);
      chk("R6 wake drops after pop", {30'b0, b_irq, b_wake}, 0);
      op(1, 1, 0, 4'd8, 0);
    end

    // R5 R6 transmit-free interrupt per channel
    for (int ch = 0; ch < 4; ch++) begin
      op(0, 1, 0, 4'd8, 32'((4'b1 << ch)) << 8);
      chk("R5 tx free irq", {31'b0, a_irq}, 1);
      chk("R6 no wake on tx", {31'b0, a_wake}, 0);
      op(0, 1, 0, 4'(ch), 32'h7777_0000 + 32'(ch));
      chk("R5 tx busy no irq", {31'b0, a_irq}, 0);
      op(1, 0, 1, 4'(4 + ch), 0);
      chk("R5 tx free again irq", {30'b0, a_irq, a_wake}, 2);
      op(0, 1, 0, 4'd8, 0);
      chk("R5 disabled", {31'b0, a_irq}, 0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule